// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block remembers, for each recently seen taken branch, where that branch went. The fetch stage presents an instruction address and a hardware thread number on the lookup port. In the same cycle the block returns a hit flag and the predicted target address. The branch resolution logic writes entries back through the update port, giving the branch address, the resolved target and the thread. A flush input drops every stored prediction, for example after a context switch.

Storage is direct-mapped. One group of address bits, just above the instruction alignment bits, selects the entry. The bits above that group form a tag of configurable width. Each entry also records the thread that wrote it, so one thread never consumes another thread's prediction. The entry count, tag width, alignment shift, address width and thread-ID width are parameters. An entry count that is not a power of two stops elaboration with a fatal error.

Top module: `btb_direct`

## Requirements
- R1: With the default parameters (64 entries, alignment shift 2), lookup and update select entry `pc[7:2]`. Address bits `[1:0]` have no effect on which entry is used or on the result.
- R2: With the defaults (tag width 12), the tag is `pc[19:8]`. Address bits 20 and above are not compared, so addresses that differ only there alias to the same prediction.
- R3: A lookup hits only when the selected entry is valid, its stored tag equals the lookup tag, and its stored thread ID equals `lkp_tid_i`. A mismatch in any one of these gives a miss.
- R4: On a miss, `lkp_hit_o` is 0 and `lkp_target_o` is all zeros.
- R5: An update with `upd_en_i` high writes the selected entry unconditionally: it sets valid and replaces the tag, thread ID and target. The new contents are seen by lookups from the cycle after the clock edge that takes the update.
- R6: Lookup is combinational. A lookup in the same cycle as an update to the same entry returns the entry's previous contents.
- R7: Asserting `rst_ni` low, or `flush_i` high at a clock edge, invalidates every entry. Every lookup afterwards misses until a new update is taken.
- R8: When `flush_i` and `upd_en_i` are both high at one edge, the flush wins and the updated entry stays invalid.
- R9: A stored target of zero is reported with `lkp_hit_o` = 1, so it can be told apart from a miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries at the next edge |
| lkp_pc_i | input | ADDR_W | Lookup instruction address |
| lkp_tid_i | input | TID_W | Lookup thread ID |
| lkp_hit_o | output | 1 | Lookup found a matching entry |
| lkp_target_o | output | ADDR_W | Predicted target, zero on miss |
| upd_en_i | input | 1 | Write an entry at the next edge |
| upd_pc_i | input | ADDR_W | Address of the resolved branch |
| upd_tid_i | input | TID_W | Thread of the resolved branch |
| upd_target_i | input | ADDR_W | Resolved branch target |

## Verification
A valid bit that is set or cleared wrongly shows at the ports on the first lookup that selects that entry. It appears as a spurious hit or as a lost one, in the cycle right after the faulty edge. A corrupted stored tag or thread ID shows up as a hit for an alias or for another thread. A corrupted target shows as a wrong address on an otherwise correct hit. The bench keeps a shadow copy of every entry and compares every lookup against it. That comparison exposes such faults after the one update or flush that caused them.

// File: rtl/btb_pkg.sv
package btb_pkg;

  function automatic bit is_pow2(int n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int ADDR_W      = 32,
  parameter int ALIGN_SHIFT = 2,
  parameter int IDX_W       = 6,
  parameter int TAG_W       = 12
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  localparam int TAG_LSB   = ALIGN_SHIFT + IDX_W;
  localparam int TAG_AVAIL = ADDR_W - TAG_LSB;

  assign idx_o = pc_i[ALIGN_SHIFT +: IDX_W];

  generate
    if (TAG_AVAIL >= TAG_W) begin : g_tag_full
      assign tag_o = pc_i[TAG_LSB +: TAG_W];
    end else begin : g_tag_short
      // address runs out before the tag width: upper tag bits read as zero
      assign tag_o = {{(TAG_W - TAG_AVAIL){1'b0}}, pc_i[ADDR_W-1:TAG_LSB]};
    end
  endgenerate

  logic unused_pc_bits;
  assign unused_pc_bits = ^pc_i;

endmodule

// File: rtl/btb_entry_store.sv
module btb_entry_store #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6,
  parameter int TAG_W   = 12,
  parameter int TID_W   = 2,
  parameter int ADDR_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [TID_W-1:0]  wr_tid_i,
  input  logic [ADDR_W-1:0] wr_tgt_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [TID_W-1:0]  rd_tid_o,
  output logic [ADDR_W-1:0] rd_tgt_o
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [TID_W-1:0]   tid_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];

  logic wr_take;
  assign wr_take = wr_en_i && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        valid_q <= '0;
    else if (flush_i)   valid_q <= '0;
    else if (wr_en_i)   valid_q[wr_idx_i] <= 1'b1;
  end

  // payload needs no reset: valid gates every use
  always_ff @(posedge clk_i) begin
    if (wr_take) begin
      tag_q[wr_idx_i] <= wr_tag_i;
      tid_q[wr_idx_i] <= wr_tid_i;
      tgt_q[wr_idx_i] <= wr_tgt_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_tid_o   = tid_q[rd_idx_i];
  assign rd_tgt_o   = tgt_q[rd_idx_i];

  // R5
  upd_written_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !flush_i) |=> (valid_q[$past(wr_idx_i)]
                               && tag_q[$past(wr_idx_i)] == $past(wr_tag_i)
                               && tid_q[$past(wr_idx_i)] == $past(wr_tid_i)
                               && tgt_q[$past(wr_idx_i)] == $past(wr_tgt_i)));
  // R7
  flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));
  // R8
  flush_beats_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && wr_en_i) |=> !valid_q[$past(wr_idx_i)]);

endmodule

// File: rtl/btb_hit_check.sv
module btb_hit_check #(
  parameter int TAG_W  = 12,
  parameter int TID_W  = 2,
  parameter int ADDR_W = 32
) (
  input  logic              valid_i,
  input  logic [TAG_W-1:0]  ent_tag_i,
  input  logic [TID_W-1:0]  ent_tid_i,
  input  logic [ADDR_W-1:0] ent_tgt_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [TID_W-1:0]  req_tid_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] target_o
);
  logic tag_eq, tid_eq;

  assign tag_eq   = (ent_tag_i == req_tag_i);
  assign tid_eq   = (ent_tid_i == req_tid_i);
  assign hit_o    = valid_i && tag_eq && tid_eq;
  assign target_o = hit_o ? ent_tgt_i : '0;

  // R3
  always_comb begin
    hit_needs_match_chk: assert (!(hit_o === 1'b1) || (tag_eq && tid_eq));
  end

endmodule

// File: rtl/btb_direct.sv
module btb_direct #(
  parameter int NUM_ENTRIES = 64,
  parameter int TAG_W       = 12,
  parameter int ALIGN_SHIFT = 2,
  parameter int ADDR_W      = 32,
  parameter int TID_W       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] lkp_pc_i,
  input  logic [TID_W-1:0]  lkp_tid_i,
  output logic              lkp_hit_o,
  output logic [ADDR_W-1:0] lkp_target_o,
  input  logic              upd_en_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic [TID_W-1:0]  upd_tid_i,
  input  logic [ADDR_W-1:0] upd_target_i
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  if (!btb_pkg::is_pow2(NUM_ENTRIES)) begin : g_bad_entries
    $fatal(1, "btb_direct: NUM_ENTRIES must be a power of two");
  end
  if (ALIGN_SHIFT + IDX_W >= ADDR_W || TAG_W > ADDR_W) begin : g_bad_width
    $fatal(1, "btb_direct: address too narrow for index and tag");
  end

  logic [IDX_W-1:0]  lkp_idx, upd_idx;
  logic [TAG_W-1:0]  lkp_tag, upd_tag;
  logic              ent_valid;
  logic [TAG_W-1:0]  ent_tag;
  logic [TID_W-1:0]  ent_tid;
  logic [ADDR_W-1:0] ent_tgt;

  btb_addr_split #(
    .ADDR_W(ADDR_W), .ALIGN_SHIFT(ALIGN_SHIFT), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_lkp_split (
    .pc_i(lkp_pc_i), .idx_o(lkp_idx), .tag_o(lkp_tag)
  );

  btb_addr_split #(
    .ADDR_W(ADDR_W), .ALIGN_SHIFT(ALIGN_SHIFT), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_upd_split (
    .pc_i(upd_pc_i), .idx_o(upd_idx), .tag_o(upd_tag)
  );

  btb_entry_store #(
    .ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .TID_W(TID_W), .ADDR_W(ADDR_W)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .wr_en_i(upd_en_i), .wr_idx_i(upd_idx), .wr_tag_i(upd_tag),
    .wr_tid_i(upd_tid_i), .wr_tgt_i(upd_target_i),
    .rd_idx_i(lkp_idx), .rd_valid_o(ent_valid), .rd_tag_o(ent_tag),
    .rd_tid_o(ent_tid), .rd_tgt_o(ent_tgt)
  );

  btb_hit_check #(
    .TAG_W(TAG_W), .TID_W(TID_W), .ADDR_W(ADDR_W)
  ) u_hit (
    .valid_i(ent_valid), .ent_tag_i(ent_tag), .ent_tid_i(ent_tid),
    .ent_tgt_i(ent_tgt), .req_tag_i(lkp_tag), .req_tid_i(lkp_tid_i),
    .hit_o(lkp_hit_o), .target_o(lkp_target_o)
  );

  // R4
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_hit_o |-> (lkp_target_o == '0));
  // R5
  upd_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(upd_en_i && !flush_i) && lkp_pc_i == $past(upd_pc_i)
     && lkp_tid_i == $past(upd_tid_i))
    |-> (lkp_hit_o && lkp_target_o == $past(upd_target_i)));
  // R7
  no_hit_after_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_i) |-> !lkp_hit_o);

endmodule

// File: tb/tb_btb_direct.sv
module tb_btb_direct;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 64;
  localparam int TAG_W   = 12;
  localparam int SHIFT   = 2;
  localparam int ADDR_W  = 32;
  localparam int TID_W   = 2;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_i = 1'b0;
  logic [ADDR_W-1:0] lkp_pc_i = '0;
  logic [TID_W-1:0]  lkp_tid_i = '0;
  logic lkp_hit_o;
  logic [ADDR_W-1:0] lkp_target_o;
  logic upd_en_i = 1'b0;
  logic [ADDR_W-1:0] upd_pc_i = '0;
  logic [TID_W-1:0]  upd_tid_i = '0;
  logic [ADDR_W-1:0] upd_target_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic              m_v   [ENTRIES];
  logic [TAG_W-1:0]  m_tag [ENTRIES];
  logic [TID_W-1:0]  m_tid [ENTRIES];
  logic [ADDR_W-1:0] m_tgt [ENTRIES];

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_direct #(
    .NUM_ENTRIES(ENTRIES), .TAG_W(TAG_W), .ALIGN_SHIFT(SHIFT),
    .ADDR_W(ADDR_W), .TID_W(TID_W)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .lkp_pc_i(lkp_pc_i), .lkp_tid_i(lkp_tid_i),
    .lkp_hit_o(lkp_hit_o), .lkp_target_o(lkp_target_o),
    .upd_en_i(upd_en_i), .upd_pc_i(upd_pc_i), .upd_tid_i(upd_tid_i),
    .upd_target_i(upd_target_i)
  );

  function automatic int m_idx(logic [ADDR_W-1:0] pc);
    return int'(pc[SHIFT +: IDX_W]);
  endfunction
  function automatic logic [TAG_W-1:0] m_tagof(logic [ADDR_W-1:0] pc);
    return pc[SHIFT+IDX_W +: TAG_W];
  endfunction

  task automatic m_clear();
    for (int i = 0; i < ENTRIES; i++) m_v[i] = 1'b0;
  endtask

  task automatic chk(input bit ok, input string req, input logic [ADDR_W-1:0] act,
                     input logic [ADDR_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive a lookup and compare against the shadow model
  task automatic look(input logic [ADDR_W-1:0] pc, input logic [TID_W-1:0] tid,
                      input string req);
    int i;
    bit eh;
    logic [ADDR_W-1:0] et;
    lkp_pc_i = pc;
    lkp_tid_i = tid;
    #1;
    i = m_idx(pc);
    eh = m_v[i] && m_tag[i] == m_tagof(pc) && m_tid[i] == tid;
    et = eh ? m_tgt[i] : '0;
    chk(lkp_hit_o == eh, {req, " hit"}, ADDR_W'(lkp_hit_o), ADDR_W'(eh));
    chk(lkp_target_o == et, {req, " target"}, lkp_target_o, et);
  endtask

  task automatic expect_hit(input logic [ADDR_W-1:0] pc, input logic [TID_W-1:0] tid,
                            input bit exp, input string req);
    lkp_pc_i = pc;
    lkp_tid_i = tid;
    #1;
    chk(lkp_hit_o == exp, req, ADDR_W'(lkp_hit_o), ADDR_W'(exp));
  endtask

  task automatic update(input logic [ADDR_W-1:0] pc, input logic [ADDR_W-1:0] tgt,
                        input logic [TID_W-1:0] tid);
    @(negedge clk);
    upd_en_i = 1'b1; upd_pc_i = pc; upd_target_i = tgt; upd_tid_i = tid;
    @(negedge clk);
    upd_en_i = 1'b0;
    m_v[m_idx(pc)] = 1'b1;
    m_tag[m_idx(pc)] = m_tagof(pc);
    m_tid[m_idx(pc)] = tid;
    m_tgt[m_idx(pc)] = tgt;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    m_clear();
  endtask

  task automatic t_reset();
    // R7: reset state misses everywhere
    expect_hit(32'h0000_1234, 2'd0, 1'b0, "R7 reset");
    chk(lkp_target_o == '0, "R4 reset target", lkp_target_o, '0);
  endtask

  task automatic t_basic();
    update(32'h0000_4A10, 32'hCAFE_0000, 2'd1);
    look(32'h0000_4A10, 2'd1, "R5 basic");
    expect_hit(32'h0000_4A10, 2'd1, 1'b1, "R5 basic hit");
  endtask

  task automatic t_index_bits();
    update(32'h0000_3300, 32'h1111_2222, 2'd0);
    // R1: low alignment bits ignored
    expect_hit(32'h0000_3303, 2'd0, 1'b1, "R1 low bits");
    chk(lkp_target_o == 32'h1111_2222, "R1 target", lkp_target_o, 32'h1111_2222);
    // neighbouring index is another entry
    look(32'h0000_3304, 2'd0, "R1 next index");
  endtask

  task automatic t_alias();
    update(32'h0001_2340, 32'hAAAA_0001, 2'd2);
    // R2: same index, different tag bit -> miss
    expect_hit(32'h0001_2240, 2'd2, 1'b0, "R2 tag differs");
    chk(lkp_target_o == '0, "R4 alias miss target", lkp_target_o, '0);
    // R2: bits above tag ignored -> aliases
    expect_hit(32'hFF01_2340, 2'd2, 1'b1, "R2 upper bits aliased");
    chk(lkp_target_o == 32'hAAAA_0001, "R2 alias target", lkp_target_o, 32'hAAAA_0001);
    // alias overwrites
    update(32'h0001_2240, 32'hBBBB_0002, 2'd2);
    expect_hit(32'h0001_2340, 2'd2, 1'b0, "R5 alias evicts");
    look(32'h0001_2240, 2'd2, "R5 alias new");
  endtask

  task automatic t_tid();
    update(32'h0000_0880, 32'h0D0D_0000, 2'd3);
    expect_hit(32'h0000_0880, 2'd0, 1'b0, "R3 tid mismatch");
    expect_hit(32'h0000_0880, 2'd2, 1'b0, "R3 tid mismatch 2");
    expect_hit(32'h0000_0880, 2'd3, 1'b1, "R3 tid match");
  endtask

  task automatic t_overwrite_same_cycle();
    update(32'h0000_5560, 32'h0000_AAAA, 2'd1);
    @(negedge clk);
    upd_en_i = 1'b1; upd_pc_i = 32'h0000_5560; upd_target_i = 32'h0000_BBBB;
    upd_tid_i = 2'd1;
    lkp_pc_i = 32'h0000_5560; lkp_tid_i = 2'd1;
    #1;
    // R6: old contents visible in the update cycle
    chk(lkp_target_o == 32'h0000_AAAA, "R6 old value", lkp_target_o, 32'h0000_AAAA);
    @(negedge clk);
    upd_en_i = 1'b0;
    #1;
    chk(lkp_target_o == 32'h0000_BBBB, "R5 overwrite", lkp_target_o, 32'h0000_BBBB);
    m_tgt[m_idx(32'h0000_5560)] = 32'h0000_BBBB;
  endtask

  task automatic t_zero_target();
    update(32'h0000_7700, 32'h0, 2'd0);
    expect_hit(32'h0000_7700, 2'd0, 1'b1, "R9 zero target hit");
    chk(lkp_target_o == '0, "R9 zero target", lkp_target_o, '0);
  endtask

  task automatic t_flush();
    update(32'h0000_9000, 32'h9999_0000, 2'd0);
    do_flush();
    expect_hit(32'h0000_9000, 2'd0, 1'b0, "R7 flush");
    expect_hit(32'h0000_4A10, 2'd1, 1'b0, "R7 flush other");
  endtask

  task automatic t_flush_vs_update();
    @(negedge clk);
    flush_i = 1'b1; upd_en_i = 1'b1;
    upd_pc_i = 32'h0000_6660; upd_target_i = 32'h6666_0000; upd_tid_i = 2'd0;
    @(negedge clk);
    flush_i = 1'b0; upd_en_i = 1'b0;
    m_clear();
    expect_hit(32'h0000_6660, 2'd0, 1'b0, "R8 flush wins");
    chk(lkp_target_o == '0, "R8 target", lkp_target_o, '0);
  endtask

  task automatic t_reset_midrun();
    update(32'h0000_1230, 32'h1230_0000, 2'd1);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    expect_hit(32'h0000_1230, 2'd1, 1'b0, "R7 async reset");
    @(negedge clk);
    rst_ni = 1'b1;
    m_clear();
  endtask

  task automatic t_sweep();
    logic [ADDR_W-1:0] pool [8];
    for (int i = 0; i < 8; i++)
      pool[i] = {$urandom} & 32'h0003_3F0F;
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 3) != 0)
        update(pool[$urandom_range(0, 7)], $urandom, TID_W'($urandom_range(0, 3)));
      else
        @(negedge clk);
      look(pool[$urandom_range(0, 7)], TID_W'($urandom_range(0, 3)), "R3 sweep");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_clear();
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    t_basic();
    t_index_bits();
    t_alias();
    t_tid();
    t_overwrite_same_cycle();
    t_zero_target();
    t_flush();
    t_flush_vs_update();
    t_reset_midrun();
    t_sweep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule